// File: doc/BRIEF.md
# Posted-Write Ordering Counter Checker

This block watches a packet stream for one forbidden kind of reordering. Posted writes may overtake earlier reads, but a read or a completion must never overtake a posted write that was sent before it. The transmit side sorts every packet it accepts into one of three kinds. It keeps two small counters of posted writes sent, one for reads and one for completions. Each read or completion carries the counter of its own kind as a stamp, and sending it clears that counter. If a posted write arrives while either counter sits at its highest value, the transmit side first inserts a sync packet. The sync packet carries both counters and zeroes them, so neither counter can wrap.

Between the two sides, a packet FIFO models the link, and the bench can reorder it. The FIFO can hold packets back, and it can hand out the second entry before the head. The receive side keeps two mirror counters of posted writes received. On a read or completion it subtracts the stamp from the matching counter, and on a sync packet it subtracts both stamps. A counter that is lower than the stamp it is compared with proves that writes were overtaken. The receive side then raises a sticky violation flag and records the kind of packet that exposed it.

Top module: `pwo_order_guard`

## Requirements
- R1: After reset, no violation is flagged, `viol_class` is 0, no packet is delivered, and `in_ready` is high.
- R2: Packet kinds are encoded as 0 posted write, 1 read, 2 completion and 3 sync. An accepted posted write increments both transmit counters. A read is delivered with `rx_stamp_rd` equal to the read counter, and that counter is then cleared. A completion is delivered with `rx_stamp_cpl` equal to the completion counter, and that counter is then cleared. A read carries 0 in its completion stamp and the other way round, and posted writes carry 0 in both stamps.
- R3: When a posted write is offered while either transmit counter equals 2^CNT_W-1, `in_ready` is low for exactly one cycle. During that cycle a sync packet (kind 3) carrying both counters enters the link ahead of the write, and both counters return to 0.
- R4: A stream delivered in sending order raises no violation. Neither does a stream in which posted writes overtake reads.
- R5: A read whose read stamp exceeds the receiver's read-class count sets `viol_flag` with `viol_class` 1 in the cycle it is delivered.
- R6: A completion whose completion stamp exceeds the receiver's completion-class count sets `viol_flag` with `viol_class` 2 in the cycle it is delivered.
- R7: A sync packet whose stamps exceed the receiver's counts sets `viol_flag` with `viol_class` 3. A read that was moved ahead of a sync, past a write sent after that sync, is therefore caught no later than the sync itself.
- R8: `viol_flag` stays set, and `viol_class` keeps the class of the first violation, until `viol_clear` is high at a clock edge. Clearing takes priority over a new detection in the same cycle.
- R9: An upstream packet of kind 3 is accepted and discarded. Nothing is delivered for it and no counter changes.
- R10: When `chan_hold` is low, the link delivers one packet per cycle. It delivers the second-oldest entry when `chan_swap` is high and at least two are queued, and the oldest entry otherwise. `in_ready` is low while the link holds FIFO_DEPTH packets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Upstream packet offered |
| in_ready | output | 1 | Upstream packet accepted this cycle |
| in_kind | input | 2 | Kind of the offered packet (0 write, 1 read, 2 completion, 3 discarded) |
| in_tag | input | TAG_W | Identifier carried through to the receiver |
| chan_hold | input | 1 | Stop delivery from the link |
| chan_swap | input | 1 | Deliver the second-oldest entry first |
| viol_clear | input | 1 | Clear the sticky violation |
| viol_flag | output | 1 | Sticky ordering violation |
| viol_class | output | 2 | Kind of packet that exposed the first violation |
| rx_valid | output | 1 | A packet was delivered to the receiver |
| rx_kind | output | 2 | Kind of the delivered packet |
| rx_tag | output | TAG_W | Tag of the delivered packet |
| rx_stamp_rd | output | CNT_W | Read-class stamp of the delivered packet |
| rx_stamp_cpl | output | CNT_W | Completion-class stamp of the delivered packet |

## Verification
The bench first runs a mixed in-order stream through the block and checks each stamp. A design that forgot to clear the counter of the kind just sent would deliver stamps that grow too large. The bench also has writes overtake a read and then sends a second read. A receiver that zeroes its counter where it should subtract would report a false violation there. The hardest case moves a read ahead of a sync packet but past a write sent after that sync. The flag must stay low until the sync arrives and then rise with class 3, so a design without the sync comparison would miss the violation entirely. The bench further checks the one-cycle stall before a sync, the retention of the first violation class when a second violation follows, and the full-FIFO backpressure.

// File: rtl/pwo_pkg.sv
package pwo_pkg;

  parameter int unsigned CNT_W = 8;
  parameter int unsigned TAG_W = 8;

  typedef logic [CNT_W-1:0] cnt_t;

  localparam cnt_t CNT_TOP = '1;

  typedef enum logic [1:0] {
    K_POST = 2'd0,
    K_READ = 2'd1,
    K_CPL  = 2'd2,
    K_SYNC = 2'd3
  } kind_e;

  typedef struct packed {
    kind_e            kind;
    logic [TAG_W-1:0] tag;
    cnt_t             st_rd;
    cnt_t             st_cpl;
  } pkt_t;

  function automatic cnt_t sat_inc(cnt_t c);
    return (c == CNT_TOP) ? c : c + cnt_t'(1);
  endfunction

  function automatic cnt_t floor_sub(cnt_t have, cnt_t stamp);
    return (have < stamp) ? '0 : have - stamp;
  endfunction

  function automatic logic overtaken(cnt_t have, cnt_t stamp);
    return have < stamp;
  endfunction

endpackage

// File: rtl/pwo_tx_stamper.sv
module pwo_tx_stamper
  import pwo_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [1:0]       in_kind,
  input  logic [TAG_W-1:0] in_tag,
  output logic             in_ready,
  input  logic             chan_full,
  output logic             push,
  output pkt_t             push_pkt
);

  cnt_t  cnt_rd, cnt_cpl;
  kind_e kind_in;
  logic  at_top;
  logic  need_sync;
  logic  sync_ins;
  logic  accept;

  assign kind_in   = kind_e'(in_kind);
  assign at_top    = (cnt_rd == CNT_TOP) || (cnt_cpl == CNT_TOP);
  assign need_sync = in_valid && (kind_in == K_POST) && at_top;
  assign sync_ins  = need_sync && !chan_full;
  assign in_ready  = !chan_full && !need_sync;
  assign accept    = in_valid && in_ready;
  assign push      = sync_ins || (accept && (kind_in != K_SYNC));

  always_comb begin
    push_pkt        = '0;
    push_pkt.kind   = kind_in;
    push_pkt.tag    = in_tag;
    if (sync_ins) begin
      push_pkt.kind   = K_SYNC;
      push_pkt.tag    = '0;
      push_pkt.st_rd  = cnt_rd;
      push_pkt.st_cpl = cnt_cpl;
    end else if (kind_in == K_READ) begin
      push_pkt.st_rd  = cnt_rd;
    end else if (kind_in == K_CPL) begin
      push_pkt.st_cpl = cnt_cpl;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_rd  <= '0;
      cnt_cpl <= '0;
    end else if (sync_ins) begin
      cnt_rd  <= '0;
      cnt_cpl <= '0;
    end else if (accept) begin
      unique case (kind_in)
        K_POST: begin
          cnt_rd  <= cnt_rd + cnt_t'(1);
          cnt_cpl <= cnt_cpl + cnt_t'(1);
        end
        K_READ: cnt_rd  <= '0;
        K_CPL:  cnt_cpl <= '0;
        default: ;
      endcase
    end
  end

  assert_sync_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sync_ins |-> !in_ready);
  assert_sync_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sync_ins |=> (cnt_rd == '0) && (cnt_cpl == '0));
  assert_no_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_rd == CNT_TOP) |=> (cnt_rd == CNT_TOP) || (cnt_rd == '0));
  assert_read_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && kind_in == K_READ) |=> (cnt_rd == '0));

endmodule

// File: rtl/pwo_link_fifo.sv
module pwo_link_fifo
  import pwo_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  pkt_t push_pkt,
  output logic full,
  input  logic hold,
  input  logic swap,
  output logic pop,
  output pkt_t pop_pkt
);

  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam int unsigned IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  pkt_t          mem [DEPTH];
  pkt_t          nxt [DEPTH];
  logic [CW-1:0] cnt, cnt_after, cnt_nxt;
  logic          sel;

  assign full    = (cnt == CW'(DEPTH));
  assign pop     = !hold && (cnt != '0);
  assign sel     = swap && (cnt >= CW'(2));
  assign pop_pkt = sel ? mem[1] : mem[0];

  assign cnt_after = cnt - CW'(pop);
  assign cnt_nxt   = cnt_after + CW'(push);

  always_comb begin
    for (int i = 0; i < int'(DEPTH); i++) nxt[i] = mem[i];
    if (pop) begin
      for (int i = 0; i < int'(DEPTH) - 1; i++) begin
        if (i >= int'(sel)) nxt[i] = mem[i+1];
      end
    end
    if (push && (cnt_after < CW'(DEPTH))) nxt[cnt_after[IW-1:0]] = push_pkt;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < int'(DEPTH); i++) mem[i] <= nxt[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end

  assert_no_push_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && full));
  assert_count_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  assert_hold_freezes_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !push) |=> $stable(cnt));

endmodule

// File: rtl/pwo_rx_checker.sv
module pwo_rx_checker
  import pwo_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pop,
  input  pkt_t             pop_pkt,
  input  logic             viol_clear,
  output logic             viol_flag,
  output logic [1:0]       viol_class,
  output logic             rx_valid,
  output pkt_t             rx_pkt
);

  cnt_t  seen_rd, seen_cpl;
  logic  short_rd, short_cpl;
  logic  detect;
  kind_e det_kind;

  assign short_rd  = overtaken(seen_rd, pop_pkt.st_rd);
  assign short_cpl = overtaken(seen_cpl, pop_pkt.st_cpl);

  always_comb begin
    detect   = 1'b0;
    det_kind = K_POST;
    if (pop) begin
      unique case (pop_pkt.kind)
        K_READ: begin detect = short_rd;  det_kind = K_READ; end
        K_CPL:  begin detect = short_cpl; det_kind = K_CPL;  end
        K_SYNC: begin detect = short_rd || short_cpl; det_kind = K_SYNC; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_rd  <= '0;
      seen_cpl <= '0;
    end else if (pop) begin
      unique case (pop_pkt.kind)
        K_POST: begin
          seen_rd  <= sat_inc(seen_rd);
          seen_cpl <= sat_inc(seen_cpl);
        end
        K_READ: seen_rd  <= floor_sub(seen_rd, pop_pkt.st_rd);
        K_CPL:  seen_cpl <= floor_sub(seen_cpl, pop_pkt.st_cpl);
        K_SYNC: begin
          seen_rd  <= floor_sub(seen_rd, pop_pkt.st_rd);
          seen_cpl <= floor_sub(seen_cpl, pop_pkt.st_cpl);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      viol_flag  <= 1'b0;
      viol_class <= 2'd0;
    end else if (viol_clear) begin
      viol_flag  <= 1'b0;
      viol_class <= 2'd0;
    end else if (!viol_flag && detect) begin
      viol_flag  <= 1'b1;
      viol_class <= det_kind;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_valid <= 1'b0;
      rx_pkt   <= '0;
    end else begin
      rx_valid <= pop;
      rx_pkt   <= pop ? pop_pkt : '0;
    end
  end

  assert_read_detect_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && pop_pkt.kind == K_READ && short_rd && !viol_clear) |=> viol_flag);
  assert_cpl_detect_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && pop_pkt.kind == K_CPL && short_cpl && !viol_clear) |=> viol_flag);
  assert_sync_detect_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && pop_pkt.kind == K_SYNC && (short_rd || short_cpl) && !viol_clear)
      |=> viol_flag);
  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_flag && !viol_clear) |=> viol_flag && $stable(viol_class));
  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    viol_clear |=> !viol_flag);

endmodule

// File: rtl/pwo_order_guard.sv
module pwo_order_guard
  import pwo_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [1:0]       in_kind,
  input  logic [TAG_W-1:0] in_tag,
  input  logic             chan_hold,
  input  logic             chan_swap,
  input  logic             viol_clear,
  output logic             viol_flag,
  output logic [1:0]       viol_class,
  output logic             rx_valid,
  output logic [1:0]       rx_kind,
  output logic [TAG_W-1:0] rx_tag,
  output logic [CNT_W-1:0] rx_stamp_rd,
  output logic [CNT_W-1:0] rx_stamp_cpl
);

  logic push, full, pop;
  pkt_t push_pkt, pop_pkt, rx_pkt;

  pwo_tx_stamper u_tx (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_kind(in_kind),
    .in_tag(in_tag), .in_ready(in_ready), .chan_full(full),
    .push(push), .push_pkt(push_pkt)
  );

  pwo_link_fifo #(.DEPTH(FIFO_DEPTH)) u_link (
    .clk(clk), .rst_n(rst_n), .push(push), .push_pkt(push_pkt), .full(full),
    .hold(chan_hold), .swap(chan_swap), .pop(pop), .pop_pkt(pop_pkt)
  );

  pwo_rx_checker u_rx (
    .clk(clk), .rst_n(rst_n), .pop(pop), .pop_pkt(pop_pkt),
    .viol_clear(viol_clear), .viol_flag(viol_flag), .viol_class(viol_class),
    .rx_valid(rx_valid), .rx_pkt(rx_pkt)
  );

  assign rx_kind      = rx_pkt.kind;
  assign rx_tag       = rx_pkt.tag;
  assign rx_stamp_rd  = rx_pkt.st_rd;
  assign rx_stamp_cpl = rx_pkt.st_cpl;

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> !viol_flag && !rx_valid);

endmodule

// File: tb/pwo_order_guard_tb.sv
module pwo_order_guard_tb;
  import pwo_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [1:0] in_kind = 2'd0;
  logic [TAG_W-1:0] in_tag = '0;
  logic chan_hold = 1'b1;
  logic chan_swap = 1'b0;
  logic viol_clear = 1'b0;
  logic viol_flag;
  logic [1:0] viol_class;
  logic rx_valid;
  logic [1:0] rx_kind;
  logic [TAG_W-1:0] rx_tag;
  logic [CNT_W-1:0] rx_stamp_rd, rx_stamp_cpl;

  int n_checks = 0;
  int n_fail = 0;
  int stalls = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pwo_order_guard u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_kind(in_kind), .in_tag(in_tag), .chan_hold(chan_hold),
    .chan_swap(chan_swap), .viol_clear(viol_clear), .viol_flag(viol_flag),
    .viol_class(viol_class), .rx_valid(rx_valid), .rx_kind(rx_kind),
    .rx_tag(rx_tag), .rx_stamp_rd(rx_stamp_rd), .rx_stamp_cpl(rx_stamp_cpl)
  );

  // {kind[18:17], expect_delivery[16], stamp_rd[15:8], stamp_cpl[7:0]}
  localparam int NV = 15;
  localparam logic [18:0] VEC [NV] = '{
    {2'd0, 1'b1, 8'd0, 8'd0},
    {2'd0, 1'b1, 8'd0, 8'd0},
    {2'd1, 1'b1, 8'd2, 8'd0},
    {2'd2, 1'b1, 8'd0, 8'd2},
    {2'd0, 1'b1, 8'd0, 8'd0},
    {2'd2, 1'b1, 8'd0, 8'd1},
    {2'd1, 1'b1, 8'd1, 8'd0},
    {2'd1, 1'b1, 8'd0, 8'd0},
    {2'd3, 1'b0, 8'd0, 8'd0},
    {2'd0, 1'b1, 8'd0, 8'd0},
    {2'd0, 1'b1, 8'd0, 8'd0},
    {2'd3, 1'b0, 8'd0, 8'd0},
    {2'd0, 1'b1, 8'd0, 8'd0},
    {2'd1, 1'b1, 8'd3, 8'd0},
    {2'd2, 1'b1, 8'd0, 8'd3}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; chan_hold = 1'b1; chan_swap = 1'b0;
    viol_clear = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // offer one packet, wait until accepted; counts stalled cycles
  task automatic send(input logic [1:0] k, input logic [TAG_W-1:0] t);
    bit r;
    stalls = 0;
    @(negedge clk);
    in_valid = 1'b1; in_kind = k; in_tag = t;
    forever begin
      #1 r = in_ready;
      @(posedge clk);
      if (r) break;
      stalls++;
      @(negedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic burst_writes(input int n);
    @(negedge clk);
    in_valid = 1'b1; in_kind = 2'd0; in_tag = '0;
    repeat (n) @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // release exactly one packet from the link; outputs valid on return
  task automatic pop_one(input bit sw);
    @(negedge clk);
    chan_hold = 1'b0; chan_swap = sw;
    @(posedge clk);
    @(negedge clk);
    chan_hold = 1'b1; chan_swap = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    #1;
    check(!viol_flag, "R1 flag", viol_flag, 0);
    check(viol_class == 2'd0, "R1 class", viol_class, 0);
    check(!rx_valid, "R1 rx_valid", rx_valid, 0);
    check(in_ready, "R1 in_ready", in_ready, 1);

    // in-order table walk: R2 stamps, R9 discard, R4 no violation
    chan_hold = 1'b0;
    for (int i = 0; i < NV; i++) begin
      send(VEC[i][18:17], TAG_W'(i));
      @(posedge clk);
      @(negedge clk);
      if (VEC[i][16]) begin
        check(rx_valid && rx_tag == TAG_W'(i) && rx_kind == VEC[i][18:17],
              "R2 delivery", {rx_valid, rx_kind}, {1'b1, VEC[i][18:17]});
        check(rx_stamp_rd == VEC[i][15:8], "R2 read stamp", rx_stamp_rd, VEC[i][15:8]);
        check(rx_stamp_cpl == VEC[i][7:0], "R2 cpl stamp", rx_stamp_cpl, VEC[i][7:0]);
      end else begin
        check(!rx_valid, "R9 discard", rx_valid, 0);
      end
    end
    check(!viol_flag, "R4 in-order stream", viol_flag, 0);

    // R4: write overtakes read, then a later read stamped with that write
    do_reset();
    send(2'd1, 8'h10);
    send(2'd0, 8'h11);
    pop_one(1'b1);
    check(rx_tag == 8'h11, "R10 swap picks second", rx_tag, 8'h11);
    pop_one(1'b0);
    check(!viol_flag, "R4 write passes read", viol_flag, 0);
    send(2'd1, 8'h12);
    pop_one(1'b0);
    check(rx_stamp_rd == 8'd1, "R2 stamp after passing write", rx_stamp_rd, 1);
    check(!viol_flag, "R4 subtract not clear", viol_flag, 0);

    // R5 read overtakes write; R8 stickiness and first-class retention
    do_reset();
    send(2'd0, 8'h20);
    send(2'd1, 8'h21);
    pop_one(1'b1);
    check(viol_flag && viol_class == 2'd1, "R5 read passes write",
          {viol_flag, viol_class}, 3'b101);
    pop_one(1'b0);
    check(viol_flag, "R8 sticky", viol_flag, 1);
    send(2'd0, 8'h22);
    send(2'd2, 8'h23);
    pop_one(1'b1);
    check(viol_flag && viol_class == 2'd1, "R8 first class kept",
          viol_class, 1);
    pop_one(1'b0);
    @(negedge clk); viol_clear = 1'b1;
    @(negedge clk); viol_clear = 1'b0;
    check(!viol_flag && viol_class == 2'd0, "R8 clear", {viol_flag, viol_class}, 0);

    // R6 completion overtakes write
    do_reset();
    send(2'd0, 8'h30);
    send(2'd2, 8'h31);
    pop_one(1'b1);
    check(rx_kind == 2'd2 && rx_stamp_cpl == 8'd1, "R6 cpl stamp", rx_stamp_cpl, 1);
    check(viol_flag && viol_class == 2'd2, "R6 cpl passes write",
          {viol_flag, viol_class}, 3'b110);

    // R3 sync insertion on a clean path
    do_reset();
    chan_hold = 1'b0;
    burst_writes(255);
    repeat (3) @(negedge clk);
    chan_hold = 1'b1;
    send(2'd0, 8'h40);
    check(stalls == 1, "R3 one-cycle stall", stalls, 1);
    send(2'd1, 8'h41);
    pop_one(1'b0);
    check(rx_kind == 2'd3, "R3 sync kind", rx_kind, 3);
    check(rx_stamp_rd == 8'd255 && rx_stamp_cpl == 8'd255, "R3 sync stamps",
          rx_stamp_rd, 255);
    pop_one(1'b0);
    check(rx_kind == 2'd0 && rx_tag == 8'h40, "R3 write after sync", rx_tag, 8'h40);
    pop_one(1'b0);
    check(rx_stamp_rd == 8'd1, "R3 counters restarted", rx_stamp_rd, 1);
    check(!viol_flag, "R4 clean sync path", viol_flag, 0);

    // R7 read moved ahead of sync past a post-sync write
    do_reset();
    chan_hold = 1'b0;
    burst_writes(255);
    repeat (3) @(negedge clk);
    chan_hold = 1'b1;
    send(2'd0, 8'h50);
    send(2'd1, 8'h51);
    pop_one(1'b1);
    pop_one(1'b1);
    check(rx_tag == 8'h51 && !viol_flag, "R7 not caught before sync",
          viol_flag, 0);
    pop_one(1'b0);
    check(rx_kind == 2'd3 && viol_flag && viol_class == 2'd3, "R7 caught at sync",
          {viol_flag, viol_class}, 3'b111);

    // R10 full backpressure and plain order
    do_reset();
    for (int i = 0; i < 16; i++) send(2'd0, TAG_W'(i));
    @(negedge clk);
    in_valid = 1'b1; in_kind = 2'd0;
    #1 check(!in_ready, "R10 full stalls input", in_ready, 0);
    @(negedge clk);
    in_valid = 1'b0;
    pop_one(1'b0);
    check(rx_tag == 8'd0, "R10 oldest first", rx_tag, 0);
    pop_one(1'b1);
    check(rx_tag == 8'd2, "R10 swap second", rx_tag, 2);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule